// File: doc/BRIEF.md
# Parallel Column Decompressor for Beam Row Chains

This block sits between a token parser and a grid of beam dose cells that are linked row by row into serial shift chains. It accepts decoded tokens for one column of the array at a time. Zero and nonzero doses are loaded into one staging lane per row. All lanes then shift their doses into the heads of their row chains together, so the zero doses of a column cost no more chain time than a single dose. A token meaning "whole column zero" fills every lane with zero in one step. A token meaning "whole frame zero" skips the frame without any shifting.

Once the last column of a frame has been shifted in, the block pulses a common unload command so that every cell latches its dose at the same time. The token stream carries the columns of a frame from the far end of the chain to the near end. After the last column, every cell therefore holds its own dose. A busy flag marks a frame that has started but is not yet complete. Input ready drops while the chains are shifting.

Top module: `col_decomp_fanout`

## Requirements
- R1: After synchronous active-low reset, `si`, `shift`, `unload`, `frame_skip` and `busy` are all low and `tok_ready` is high.
- R2: Within a column, accepted tokens of kind 0 (zero dose) and kind 1 (explicit dose) go to rows 0, 1, …, ROWS-1 in order of acceptance. A kind-0 token loads zero whatever is on `tok_dose`, and a kind-1 token loads `tok_dose`.
- R3: Accepting the ROWS-th dose token of a column starts a shift on the next cycle. During the shift every bit of `shift` is high for exactly DW consecutive cycles, and each row's `si` carries its dose MSB first.
- R4: `tok_ready` is low in every cycle in which `shift` is asserted.
- R5: A kind-2 token (column zero), accepted at the start of a column, puts zero into every row for that column and starts the same DW-cycle shift on the next cycle.
- R6: The k-th column accepted in a frame (counting from 0) ends in cell COLS-1-k of every row chain, where cell 0 is the cell nearest the chain head.
- R7: One cycle after the last shift cycle of the COLS-th column, `unload` is high for exactly one cycle. It is asserted once per frame.
- R8: A kind-3 token (frame zero), accepted at the start of a frame, raises `frame_skip` for one cycle on the next cycle. It causes no shifting and leaves the chain contents unchanged.
- R9: `busy` is high from the cycle after the first token of a frame is accepted until the frame completes. It is low in the cycle where `unload` or `frame_skip` is high.
- R10: `unload` and `frame_skip` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_valid | input | 1 | Token present |
| tok_kind | input | 2 | 0 zero dose, 1 explicit dose, 2 column zero, 3 frame zero |
| tok_dose | input | DW | Dose value for kind 1 |
| tok_ready | output | 1 | Token accepted when high together with tok_valid |
| si | output | ROWS | Serial dose bit into each row chain head |
| shift | output | ROWS | Shift strobe for each row chain |
| unload | output | 1 | One-cycle common latch command at the end of a frame |
| frame_skip | output | 1 | One-cycle pulse for an all-zero frame |
| busy | output | 1 | Frame in progress |

## Verification
The first frame mixes explicit and zero doses, and some zero tokens carry a non-zero dose field. This shows whether each row's lane selection and the zero override are correct, and a reconstructed chain separates MSB-first ordering from its reverse. The second frame uses column-zero tokens around an explicit column, which tells a lane clear apart from stale staging data. A frame-zero token between frames checks that nothing shifts and the chains keep their contents. A repeat of the mixed frame after the skip shows that the column and row counters restart cleanly.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
// Shared types for the column decompressor: token kinds and controller states.
package dcd_pkg;
    typedef enum logic [1:0] {
        TK_ZERO = 2'd0,
        TK_DOSE = 2'd1,
        TK_COLZ = 2'd2,
        TK_FRMZ = 2'd3
    } tok_kind_t;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_SHIFT,
        ST_UNLOAD,
        ST_SKIP
    } dcd_state_t;
endpackage

// File: rtl/dcd_row_lane.sv
`timescale 1ns/1ps
// One staging lane per row: holds a column's dose for its row and serialises
// it MSB first into the row chain head while shift_en is high.
// Assumes load, clear and shift are never requested in the same cycle.
module dcd_row_lane #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    input  logic          clear,
    input  logic          shift_en,
    output logic          ser_bit
);
    logic [DW-1:0] stage;

    // Staging register: load, clear or shift left by one.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage <= '0;
        else if (clear)    stage <= '0;
        else if (load_en)  stage <= load_val;
        else if (shift_en) stage <= {stage[DW-2:0], 1'b0};
    end

    assign ser_bit = stage[DW-1];
endmodule

// File: rtl/dcd_ctrl.sv
`timescale 1ns/1ps
// Controller: steers dose tokens to row lanes, runs the DW-cycle column
// shift, counts columns and issues unload or frame skip.
// Assumes column-zero tokens arrive only at a column start and frame-zero
// tokens only at a frame start.
module dcd_ctrl
    import dcd_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    parameter int DW   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [1:0]      tok_kind,
    output logic            tok_ready,
    output logic [ROWS-1:0] wr_sel,
    output logic            clr_all,
    output logic            shift_on,
    output logic            unload,
    output logic            frame_skip,
    output logic            busy
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    dcd_state_t    state;
    logic [RW-1:0] row_idx;
    logic [CW-1:0] col_idx;
    logic [BW-1:0] bit_idx;
    logic          take;
    logic          is_dose;

    // Handshake and state-decoded outputs.
    always_comb begin
        tok_ready  = (state == ST_COLLECT);
        take       = tok_valid && tok_ready;
        is_dose    = (tok_kind == TK_ZERO) || (tok_kind == TK_DOSE);
        shift_on   = (state == ST_SHIFT);
        unload     = (state == ST_UNLOAD);
        frame_skip = (state == ST_SKIP);
        busy       = (state == ST_SHIFT) ||
                     ((state == ST_COLLECT) && ((row_idx != '0) || (col_idx != '0)));
        clr_all    = take && (tok_kind == TK_COLZ);
    end

    // Lane write select: one-hot on the current row for a dose token.
    always_comb begin
        wr_sel = '0;
        if (take && is_dose) wr_sel[row_idx] = 1'b1;
    end

    // Sequencer: row steering, column shift timing and frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_COLLECT;
            row_idx <= '0;
            col_idx <= '0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_COLLECT: begin
                    if (take) begin
                        if (tok_kind == TK_FRMZ) begin
                            state <= ST_SKIP;
                        end else if (tok_kind == TK_COLZ) begin
                            row_idx <= '0;
                            bit_idx <= '0;
                            state   <= ST_SHIFT;
                        end else if (row_idx == RW'(ROWS - 1)) begin
                            row_idx <= '0;
                            bit_idx <= '0;
                            state   <= ST_SHIFT;
                        end else begin
                            row_idx <= row_idx + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (bit_idx == BW'(DW - 1)) begin
                        if (col_idx == CW'(COLS - 1)) begin
                            col_idx <= '0;
                            state   <= ST_UNLOAD;
                        end else begin
                            col_idx <= col_idx + 1'b1;
                            state   <= ST_COLLECT;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: state <= ST_COLLECT;
            endcase
        end
    end
endmodule

// File: rtl/col_decomp_fanout.sv
`timescale 1ns/1ps
// Top: parallel column decompressor feeding ROWS serial row chains.
// One staging lane per row; all lanes shift together for DW cycles per
// column. Assumes the token stream delivers the far-end column first.
module col_decomp_fanout
    import dcd_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 3,
    parameter int DW   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [1:0]      tok_kind,
    input  logic [DW-1:0]   tok_dose,
    output logic            tok_ready,
    output logic [ROWS-1:0] si,
    output logic [ROWS-1:0] shift,
    output logic            unload,
    output logic            frame_skip,
    output logic            busy
);
    logic [ROWS-1:0] wr_sel;
    logic            clr_all;
    logic            shift_on;
    logic [DW-1:0]   lane_val;

    // Zero-dose tokens load zero regardless of the dose field.
    always_comb lane_val = (tok_kind == TK_DOSE) ? tok_dose : '0;

    dcd_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_ready(tok_ready), .wr_sel(wr_sel), .clr_all(clr_all),
        .shift_on(shift_on), .unload(unload), .frame_skip(frame_skip), .busy(busy)
    );

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_lane
            dcd_row_lane #(.DW(DW)) u_lane (
                .clk(clk), .rst_n(rst_n), .load_en(wr_sel[r]), .load_val(lane_val),
                .clear(clr_all), .shift_en(shift_on), .ser_bit(si[r])
            );
        end
    endgenerate

    assign shift = {ROWS{shift_on}};
endmodule

// File: rtl/dcd_chk.sv
`timescale 1ns/1ps
// Checker bound to the top: protocol properties on the row-chain outputs.
module dcd_chk #(
    parameter int ROWS = 4,
    parameter int DW   = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tok_ready,
    input logic [ROWS-1:0] shift,
    input logic            unload,
    input logic            frame_skip,
    input logic            busy
);
    localparam int RNW = $clog2(DW + 1) + 1;
    logic [RNW-1:0] run;

    // Length of the current run of shift cycles before this one.
    always_ff @(posedge clk) begin
        if (!rst_n)      run <= '0;
        else if (|shift) run <= run + 1'b1;
        else             run <= '0;
    end

    // R3
    shift_all_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift == '0) || (shift == '1));
    // R3
    shift_run_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|shift) |-> (run < RNW'(DW)));
    // R3
    shift_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|shift) && (run != '0)) |-> (run == RNW'(DW)));
    // R4
    ready_low_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|shift) |-> !tok_ready);
    // R7
    unload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unload |=> !unload);
    // R8
    skip_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_skip |-> (shift == '0));
    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unload || frame_skip) |-> !busy);
    // R10
    no_dual_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(unload && frame_skip));
endmodule

bind col_decomp_fanout dcd_chk #(.ROWS(ROWS), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_ready(tok_ready), .shift(shift),
    .unload(unload), .frame_skip(frame_skip), .busy(busy)
);

// File: tb/sim_col_decomp_fanout.sv
`timescale 1ns/1ps
// Directed bench: models each row chain from si/shift and checks cell contents.
module sim_col_decomp_fanout;
    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int DW   = 10;
    localparam int CL   = COLS * DW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tok_valid = 1'b0;
    logic [1:0]      tok_kind = 2'd0;
    logic [DW-1:0]   tok_dose = '0;
    logic            tok_ready;
    logic [ROWS-1:0] si, shift;
    logic            unload, frame_skip, busy;

    col_decomp_fanout #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_dose(tok_dose), .tok_ready(tok_ready), .si(si), .shift(shift),
        .unload(unload), .frame_skip(frame_skip), .busy(busy)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    int n_shift = 0, n_unload = 0, n_skip = 0, run = 0;
    bit prev_all = 1'b0;
    logic [CL-1:0] chain [ROWS];
    logic [1:0]    fk [COLS][ROWS];
    logic [DW-1:0] fd [COLS][ROWS];

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Chain model and protocol monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (shift != '0) begin
                if (shift != '1) chk(0, "R3 all rows shift", int'(shift), (1 << ROWS) - 1);
                if (tok_ready)   chk(0, "R4 ready while shifting", 1, 0);
                for (int r = 0; r < ROWS; r++) chain[r] = {chain[r][CL-2:0], si[r]};
                n_shift++;
                run++;
            end else begin
                if (run != 0 && run != DW) chk(0, "R3 shift run length", run, DW);
                run = 0;
            end
            if (unload) begin
                n_unload++;
                if (!prev_all) chk(0, "R7 unload follows last shift", 0, 1);
                if (busy)      chk(0, "R9 busy low at unload", 1, 0);
            end
            if (frame_skip) begin
                n_skip++;
                if (unload) chk(0, "R10 unload with skip", 1, 0);
            end
            prev_all = (shift == '1);
        end
    end

    task automatic send_tok(input logic [1:0] k, input logic [DW-1:0] d);
        tok_valid = 1'b1;
        tok_kind  = k;
        tok_dose  = d;
        while (!tok_ready) @(negedge clk);
        @(posedge clk);
        #1;
        tok_valid = 1'b0;
    endtask

    // Sends fk/fd as one frame and checks shifting, unload and every cell.
    task automatic run_frame(input string name);
        n_shift = 0; n_unload = 0; n_skip = 0;
        for (int c = 0; c < COLS; c++) begin
            if (fk[c][0] == 2'd2) begin
                send_tok(2'd2, '1);
                chk(shift == '1, "R5 column-zero shift start", int'(shift), (1 << ROWS) - 1);
            end else begin
                for (int r = 0; r < ROWS; r++) begin
                    send_tok(fk[c][r], fd[c][r]);
                    if (c == 0 && r == 0) chk(busy, "R9 busy after first token", int'(busy), 1);
                end
                chk(shift == '1, "R3 shift starts after last token", int'(shift), (1 << ROWS) - 1);
            end
            while (shift != '0) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(n_unload == 1, {"R7 unload count ", name}, n_unload, 1);
        chk(n_shift == COLS * DW, {"R3 shift cycles ", name}, n_shift, COLS * DW);
        chk(!busy, "R9 busy low after frame", int'(busy), 0);
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++) begin
                logic [DW-1:0] exp;
                exp = (fk[c][0] == 2'd2 || fk[c][r] == 2'd0) ? '0 : fd[c][r];
                chk(chain[r][(COLS-1-c)*DW +: DW] == exp, "R2 R5 R6 cell dose",
                    int'(chain[r][(COLS-1-c)*DW +: DW]), int'(exp));
            end
    endtask

    task automatic t_reset();
        chk(si == '0 && shift == '0, "R1 si/shift low", int'({si, shift}), 0);
        chk(!unload && !frame_skip, "R1 unload/skip low", int'({unload, frame_skip}), 0);
        chk(!busy, "R1 busy low", int'(busy), 0);
        chk(tok_ready, "R1 ready high", int'(tok_ready), 1);
    endtask

    task automatic set_mixed();
        fk[0] = '{2'd1, 2'd0, 2'd1, 2'd0}; fd[0] = '{10'h3A5, 10'h3FF, 10'h200, 10'h001};
        fk[1] = '{2'd0, 2'd0, 2'd0, 2'd0}; fd[1] = '{10'h0F0, 10'h000, 10'h111, 10'h222};
        fk[2] = '{2'd1, 2'd1, 2'd0, 2'd1}; fd[2] = '{10'h001, 10'h3FF, 10'h2AA, 10'h155};
    endtask

    task automatic t_mixed();
        set_mixed();
        run_frame("mixed");
    endtask

    task automatic t_colzero();
        fk[0] = '{2'd2, 2'd2, 2'd2, 2'd2}; fd[0] = '{10'h0, 10'h0, 10'h0, 10'h0};
        fk[1] = '{2'd1, 2'd1, 2'd1, 2'd1}; fd[1] = '{10'h081, 10'h102, 10'h204, 10'h3C3};
        fk[2] = '{2'd2, 2'd2, 2'd2, 2'd2}; fd[2] = '{10'h0, 10'h0, 10'h0, 10'h0};
        run_frame("colzero");
    endtask

    task automatic t_frmzero();
        logic [CL-1:0] snap [ROWS];
        for (int r = 0; r < ROWS; r++) snap[r] = chain[r];
        n_shift = 0; n_unload = 0; n_skip = 0;
        send_tok(2'd3, '0);
        chk(frame_skip, "R8 skip pulse next cycle", int'(frame_skip), 1);
        chk(!busy, "R9 busy low at skip", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(n_skip == 1, "R8 one skip pulse", n_skip, 1);
        chk(n_shift == 0 && n_unload == 0, "R8 no shift or unload", n_shift + n_unload, 0);
        for (int r = 0; r < ROWS; r++)
            chk(chain[r] == snap[r], "R8 chain unchanged", int'(chain[r][DW-1:0]), int'(snap[r][DW-1:0]));
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) chain[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_colzero();
        t_frmzero();
        t_mixed();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule